// File: doc/BRIEF.md
# Timestamp-Matching Event Builder

This block collects hit packets streamed in from many front-end sources and assembles them into events. Every packet carries a 24-bit timestamp, a 16-bit source address and a 64-bit hit pattern. Packets that share a timestamp are gathered into one event buffer. An event closes when a packet with another timestamp arrives, when the buffer is full, or when the input has been quiet for a programmable number of cycles. Closed events wait for a host, which reads them through a simple indexed read port.

There are `NBUF` event buffers, two by default, used in ping-pong fashion. The host returns a buffer to the free pool by writing a done strobe. If the block needs a fresh buffer and none is free, it discards the packet and counts the loss.

Each of the sources, selected by the low address bits, has its own saturating packet counter. The counters and the loss counter clear together when the host writes a clear strobe.

Top module: `ts_event_builder`

## Requirements
- R1: A packet whose timestamp equals that of the event being filled is appended at the next free entry, in arrival order. `rd_count`, `rd_ts`, `rd_addr` and `rd_hits` show it from the clock edge that accepts the packet.
- R2: A packet with a different timestamp closes the event being filled, which sets its `ready` bit. The packet then becomes entry 0 of a new event in a free buffer, with count 1 and the packet's timestamp.
- R3: An event that reaches `DEPTH` packets closes on the edge that accepts its last packet. A later packet with the same timestamp opens a new event.
- R4: With `idle_limit` = L > 0, an open event closes on the L-th consecutive clock edge that has no valid packet after its last accepted packet. With L = 0, no timeout occurs.
- R5: A packet that needs a new event while no buffer is free is discarded. The loss counter `drop_count` increases by one, and buffer contents and counts are unchanged.
- R6: A ready buffer keeps its contents and its `ready` bit until the host writes done for that buffer. A done write to a buffer that is not ready has no effect.
- R7: A done write to a ready buffer clears its `ready` bit on that edge and frees the buffer. When a new event opens, the lowest-numbered free buffer is used.
- R8: Every arriving packet, whether accepted or discarded, adds one to the counter of source `in_addr[3:0]`. `cnt_val` shows the counter chosen by `cnt_sel`.
- R9: The source counters and `drop_count` saturate at all ones.
- R10: `cnt_clear` zeroes all source counters and `drop_count` on the next edge, and it wins over an increment in the same cycle.
- R11: After reset, no buffer is ready and all counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| in_valid | input | 1 | a packet is present this cycle |
| in_ts | input | TS_W | packet timestamp |
| in_addr | input | AD_W | packet source address |
| in_hits | input | HIT_W | packet hit pattern |
| idle_limit | input | IDLE_W | quiet cycles before an open event closes, 0 disables |
| ready | output | NBUF | one bit per buffer, set while holding a closed event |
| done_wr | input | 1 | host release strobe |
| done_buf | input | clog2(NBUF) | buffer released by `done_wr` |
| rd_buf | input | clog2(NBUF) | buffer to read |
| rd_idx | input | clog2(DEPTH) | entry to read |
| rd_ts | output | TS_W | timestamp of the selected buffer |
| rd_count | output | clog2(DEPTH+1) | packet count of the selected buffer |
| rd_addr | output | AD_W | address of the selected entry |
| rd_hits | output | HIT_W | hit pattern of the selected entry |
| cnt_clear | input | 1 | clear all counters |
| cnt_sel | input | clog2(NSRC) | source counter to read |
| cnt_val | output | CNT_W | selected source counter |
| drop_count | output | CNT_W | discarded packet counter |

## Verification
Every result in this block is one register stage behind its stimulus. A packet, a done write or a clear driven before a rising edge shows on `ready`, the read port and the counters from that edge on. The read port and the counter select are combinational, so the bench drives inputs on the falling edge and samples on the next falling edge. The idle timeout is checked one sample before and on the L-th quiet edge, and once more with L = 0 over a longer quiet stretch. Expected counter values come from a per-source tally in the bench, clipped at the saturation value of the small configuration it builds.

// File: rtl/ebld_pkg.sv
package ebld_pkg;
   typedef enum logic [1:0] {
      SLOT_FREE  = 2'd0,
      SLOT_FILL  = 2'd1,
      SLOT_READY = 2'd2
   } slot_state_e;
endpackage

// File: rtl/ebld_counter_bank.sv
module ebld_counter_bank #(
   parameter int NCNT  = 17,
   parameter int CNT_W = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NCNT-1:0]            inc,
   input  logic                       clr,
   output logic [NCNT-1:0][CNT_W-1:0] cnt_all
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (NCNT < 1) begin : g_bad_ncnt
      $error("ebld_counter_bank: NCNT must be at least 1");
   end

   for (genvar i = 0; i < NCNT; i++) begin : g_cnt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                cnt_all[i] <= '0;
         else if (clr)                              cnt_all[i] <= '0;
         else if (inc[i] && cnt_all[i] != CNT_MAX)  cnt_all[i] <= cnt_all[i] + 1'b1;
      end

      AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_all[i] == CNT_MAX && !clr) |=> cnt_all[i] == CNT_MAX); // R9
      AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         clr |=> cnt_all[i] == '0); // R10
      AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr && !inc[i]) |=> cnt_all[i] == $past(cnt_all[i])); // R8
   end
endmodule

// File: rtl/ebld_slot.sv
module ebld_slot #(
   parameter int TS_W  = 24,
   parameter int AD_W  = 16,
   parameter int HIT_W = 64,
   parameter int DEPTH = 8,
   localparam int IW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             append,
   input  logic             clear,
   input  logic [TS_W-1:0]  in_ts,
   input  logic [AD_W-1:0]  in_addr,
   input  logic [HIT_W-1:0] in_hits,
   input  logic [IW-1:0]    rd_idx,
   output logic [CW-1:0]    cnt_o,
   output logic [TS_W-1:0]  ts_o,
   output logic [AD_W-1:0]  rd_addr,
   output logic [HIT_W-1:0] rd_hits
);
   logic [AD_W-1:0]  addr_mem [DEPTH];
   logic [HIT_W-1:0] hits_mem [DEPTH];
   logic [CW-1:0]    cnt_q;
   logic [TS_W-1:0]  ts_q;
   logic             wr_en;
   logic [IW-1:0]    wr_idx;

   assign wr_en  = start | append;
   assign wr_idx = start ? '0 : cnt_q[IW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ts_q  <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= CW'(1);
         ts_q  <= in_ts;
      end else if (append) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         addr_mem[wr_idx] <= in_addr;
         hits_mem[wr_idx] <= in_hits;
      end
   end

   assign cnt_o   = cnt_q;
   assign ts_o    = ts_q;
   assign rd_addr = addr_mem[rd_idx];
   assign rd_hits = hits_mem[rd_idx];

   AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH)); // R3
   AST_APPEND_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      append |-> cnt_q < CW'(DEPTH)); // R3
   AST_APPEND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (append && !clear && !start) |=> cnt_q == $past(cnt_q) + 1'b1); // R1
endmodule

// File: rtl/ebld_ctrl.sv
module ebld_ctrl
   import ebld_pkg::*;
#(
   parameter int TS_W   = 24,
   parameter int NBUF   = 2,
   parameter int DEPTH  = 8,
   parameter int IDLE_W = 16,
   localparam int BW    = $clog2(NBUF),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [TS_W-1:0]         in_ts,
   input  logic [IDLE_W-1:0]       idle_limit,
   input  logic                    done_wr,
   input  logic [BW-1:0]           done_buf,
   input  logic [NBUF-1:0][CW-1:0] slot_cnt,
   output logic [NBUF-1:0]         slot_start,
   output logic [NBUF-1:0]         slot_append,
   output logic [NBUF-1:0]         slot_clear,
   output logic [NBUF-1:0]         ready_o,
   output logic                    drop_o
);
   slot_state_e       st [NBUF];
   logic [TS_W-1:0]   open_ts;
   logic [IDLE_W-1:0] idle_ctr;
   logic [NBUF-1:0]   fill_v;
   logic              fill_act;
   logic [BW-1:0]     cur;
   logic              free_any;
   logic [BW-1:0]     fidx;
   logic              same_ts;
   logic              close_cur;
   logic              idle_fire;
   logic              idle_on;

   always_comb begin
      fill_act = 1'b0;
      cur      = '0;
      free_any = 1'b0;
      fidx     = '0;
      for (int b = 0; b < NBUF; b++) begin
         fill_v[b]  = (st[b] == SLOT_FILL);
         ready_o[b] = (st[b] == SLOT_READY);
         if (st[b] == SLOT_FILL) begin
            fill_act = 1'b1;
            cur      = BW'(b);
         end
      end
      for (int b = NBUF - 1; b >= 0; b--) begin
         if (st[b] == SLOT_FREE) begin
            free_any = 1'b1;
            fidx     = BW'(b);
         end
      end
   end

   assign same_ts   = fill_act && (in_ts == open_ts);
   assign idle_on   = fill_act && (idle_limit != '0);
   assign idle_fire = !in_valid && idle_on && (idle_ctr == idle_limit - 1'b1);

   always_comb begin
      slot_start  = '0;
      slot_append = '0;
      slot_clear  = '0;
      close_cur   = 1'b0;
      drop_o      = 1'b0;
      if (in_valid) begin
         if (same_ts) begin
            slot_append[cur] = 1'b1;
            if (slot_cnt[cur] == CW'(DEPTH - 1)) close_cur = 1'b1;
         end else begin
            close_cur = fill_act;
            if (free_any) slot_start[fidx] = 1'b1;
            else          drop_o           = 1'b1;
         end
      end else if (idle_fire) begin
         close_cur = 1'b1;
      end
      if (done_wr && st[done_buf] == SLOT_READY) slot_clear[done_buf] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < NBUF; b++) st[b] <= SLOT_FREE;
         open_ts  <= '0;
         idle_ctr <= '0;
      end else begin
         for (int b = 0; b < NBUF; b++) begin
            if (slot_clear[b])                      st[b] <= SLOT_FREE;
            else if (slot_start[b])                 st[b] <= SLOT_FILL;
            else if (close_cur && cur == BW'(b))    st[b] <= SLOT_READY;
         end
         if (in_valid && !same_ts) open_ts <= in_ts;
         if (in_valid || close_cur)  idle_ctr <= '0;
         else if (idle_on)           idle_ctr <= idle_ctr + 1'b1;
      end
   end

   AST_ONE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(fill_v) <= 1); // R2
   AST_DROP_LEAVES_NONE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      drop_o |=> fill_v == '0); // R5
   AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (done_wr && ready_o[done_buf]) |=> !ready_o[$past(done_buf)]); // R7
   AST_IDLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_on && $stable(idle_limit)) |-> idle_ctr < idle_limit); // R4

   for (genvar g = 0; g < NBUF; g++) begin : g_hold
      AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (ready_o[g] && !(done_wr && done_buf == BW'(g))) |=> ready_o[g]); // R6
   end
endmodule

// File: rtl/ts_event_builder.sv
module ts_event_builder #(
   parameter int TS_W   = 24,
   parameter int AD_W   = 16,
   parameter int HIT_W  = 64,
   parameter int NBUF   = 2,
   parameter int DEPTH  = 8,
   parameter int NSRC   = 16,
   parameter int CNT_W  = 32,
   parameter int IDLE_W = 16,
   localparam int BW    = $clog2(NBUF),
   localparam int IW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1),
   localparam int SW    = $clog2(NSRC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [TS_W-1:0]   in_ts,
   input  logic [AD_W-1:0]   in_addr,
   input  logic [HIT_W-1:0]  in_hits,
   input  logic [IDLE_W-1:0] idle_limit,
   output logic [NBUF-1:0]   ready,
   input  logic              done_wr,
   input  logic [BW-1:0]     done_buf,
   input  logic [BW-1:0]     rd_buf,
   input  logic [IW-1:0]     rd_idx,
   output logic [TS_W-1:0]   rd_ts,
   output logic [CW-1:0]     rd_count,
   output logic [AD_W-1:0]   rd_addr,
   output logic [HIT_W-1:0]  rd_hits,
   input  logic              cnt_clear,
   input  logic [SW-1:0]     cnt_sel,
   output logic [CNT_W-1:0]  cnt_val,
   output logic [CNT_W-1:0]  drop_count
);
   if (NBUF < 2 || (NBUF & (NBUF - 1)) != 0) begin : g_bad_nbuf
      $error("ts_event_builder: NBUF must be a power of two, at least 2");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("ts_event_builder: DEPTH must be a power of two, at least 2");
   end
   if (NSRC < 2 || (NSRC & (NSRC - 1)) != 0 || SW > AD_W) begin : g_bad_nsrc
      $error("ts_event_builder: NSRC must be a power of two within the address");
   end

   logic [NBUF-1:0][CW-1:0]    cnt_w;
   logic [NBUF-1:0][TS_W-1:0]  ts_w;
   logic [NBUF-1:0][AD_W-1:0]  addr_w;
   logic [NBUF-1:0][HIT_W-1:0] hits_w;
   logic [NBUF-1:0]            start_w, append_w, clear_w;
   logic                       drop_w;
   logic [NSRC:0]              inc_w;
   logic [NSRC:0][CNT_W-1:0]   cnt_all;

   ebld_ctrl #(
      .TS_W(TS_W), .NBUF(NBUF), .DEPTH(DEPTH), .IDLE_W(IDLE_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ts(in_ts),
      .idle_limit(idle_limit), .done_wr(done_wr), .done_buf(done_buf),
      .slot_cnt(cnt_w), .slot_start(start_w), .slot_append(append_w),
      .slot_clear(clear_w), .ready_o(ready), .drop_o(drop_w)
   );

   for (genvar g = 0; g < NBUF; g++) begin : g_slot
      ebld_slot #(
         .TS_W(TS_W), .AD_W(AD_W), .HIT_W(HIT_W), .DEPTH(DEPTH)
      ) u_slot (
         .clk(clk), .rst_n(rst_n), .start(start_w[g]), .append(append_w[g]),
         .clear(clear_w[g]), .in_ts(in_ts), .in_addr(in_addr), .in_hits(in_hits),
         .rd_idx(rd_idx), .cnt_o(cnt_w[g]), .ts_o(ts_w[g]),
         .rd_addr(addr_w[g]), .rd_hits(hits_w[g])
      );
   end

   for (genvar s = 0; s < NSRC; s++) begin : g_inc
      assign inc_w[s] = in_valid && (in_addr[SW-1:0] == SW'(s));
   end
   assign inc_w[NSRC] = drop_w;

   ebld_counter_bank #(
      .NCNT(NSRC + 1), .CNT_W(CNT_W)
   ) u_counters (
      .clk(clk), .rst_n(rst_n), .inc(inc_w), .clr(cnt_clear), .cnt_all(cnt_all)
   );

   assign rd_ts      = ts_w[rd_buf];
   assign rd_count   = cnt_w[rd_buf];
   assign rd_addr    = addr_w[rd_buf];
   assign rd_hits    = hits_w[rd_buf];
   assign cnt_val    = cnt_all[cnt_sel];
   assign drop_count = cnt_all[NSRC];

   AST_DROP_KEEPS_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_w && !(|clear_w)) |=> cnt_w == $past(cnt_w)); // R5
endmodule

// File: tb/tb_ts_event_builder.sv
module tb_ts_event_builder;
   localparam int TS_W = 24, AD_W = 16, HIT_W = 64, NBUF = 2, DEPTH = 4;
   localparam int NSRC = 16, CNT_W = 4, IDLE_W = 8;
   localparam int SAT = 15;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [TS_W-1:0]   in_ts = '0;
   logic [AD_W-1:0]   in_addr = '0;
   logic [HIT_W-1:0]  in_hits = '0;
   logic [IDLE_W-1:0] idle_limit = '0;
   logic [NBUF-1:0]   ready;
   logic              done_wr = 1'b0;
   logic [0:0]        done_buf = '0;
   logic [0:0]        rd_buf = '0;
   logic [1:0]        rd_idx = '0;
   logic [TS_W-1:0]   rd_ts;
   logic [2:0]        rd_count;
   logic [AD_W-1:0]   rd_addr;
   logic [HIT_W-1:0]  rd_hits;
   logic              cnt_clear = 1'b0;
   logic [3:0]        cnt_sel = '0;
   logic [CNT_W-1:0]  cnt_val;
   logic [CNT_W-1:0]  drop_count;

   int total = 0;
   int bad = 0;
   int exp_cnt [NSRC];
   int exp_drop = 0;

   always #2 clk = ~clk;

   ts_event_builder #(
      .TS_W(TS_W), .AD_W(AD_W), .HIT_W(HIT_W), .NBUF(NBUF), .DEPTH(DEPTH),
      .NSRC(NSRC), .CNT_W(CNT_W), .IDLE_W(IDLE_W)
   ) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ts(in_ts),
      .in_addr(in_addr), .in_hits(in_hits), .idle_limit(idle_limit),
      .ready(ready), .done_wr(done_wr), .done_buf(done_buf), .rd_buf(rd_buf),
      .rd_idx(rd_idx), .rd_ts(rd_ts), .rd_count(rd_count), .rd_addr(rd_addr),
      .rd_hits(rd_hits), .cnt_clear(cnt_clear), .cnt_sel(cnt_sel),
      .cnt_val(cnt_val), .drop_count(drop_count)
   );

   function automatic logic [HIT_W-1:0] hit_of(input logic [TS_W-1:0] t,
                                                input logic [AD_W-1:0] a);
      return {8'h5A, t, 16'h0, a};
   endfunction

   function automatic int clip(input int v);
      return (v > SAT) ? SAT : v;
   endfunction

   task automatic chk(input logic [HIT_W-1:0] act, input logic [HIT_W-1:0] exp,
                      input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [TS_W-1:0] t, input logic [AD_W-1:0] a);
      @(negedge clk);
      in_valid = 1'b1;
      in_ts    = t;
      in_addr  = a;
      in_hits  = hit_of(t, a);
      exp_cnt[a[3:0]]++;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic release_buf(input logic [0:0] b);
      @(negedge clk);
      done_wr  = 1'b1;
      done_buf = b;
      @(negedge clk);
      done_wr  = 1'b0;
   endtask

   task automatic look(input logic [0:0] b, input logic [1:0] i);
      rd_buf = b;
      rd_idx = i;
      #1;
   endtask

   task automatic chk_entry(input logic [0:0] b, input logic [1:0] i,
                            input logic [TS_W-1:0] t, input logic [AD_W-1:0] a,
                            input string tag);
      look(b, i);
      chk(HIT_W'(rd_addr), HIT_W'(a), {tag, " addr"});
      chk(rd_hits, hit_of(t, a), {tag, " hits"});
   endtask

   task automatic chk_counters(input string tag);
      for (int s = 0; s < NSRC; s++) begin
         cnt_sel = 4'(s);
         #1;
         chk(HIT_W'(cnt_val), HIT_W'(clip(exp_cnt[s])), tag);
      end
      chk(HIT_W'(drop_count), HIT_W'(clip(exp_drop)), {tag, " drop"});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int s = 0; s < NSRC; s++) exp_cnt[s] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: reset state
      chk(HIT_W'(ready), 0, "R11 ready after reset");
      chk_counters("R11 counters after reset");

      // R1: three packets, same timestamp, fill buffer 0 in order
      send(24'h100, 16'hA000);
      send(24'h100, 16'hB001);
      send(24'h100, 16'hC002);
      chk(HIT_W'(ready), 0, "R1 event still open");
      look(0, 0);
      chk(HIT_W'(rd_count), 3, "R1 count");
      chk(HIT_W'(rd_ts), 24'h100, "R1 timestamp");
      chk_entry(0, 0, 24'h100, 16'hA000, "R1 entry0");
      chk_entry(0, 1, 24'h100, 16'hB001, "R1 entry1");
      chk_entry(0, 2, 24'h100, 16'hC002, "R1 entry2");

      // R2: new timestamp closes buffer 0, opens buffer 1
      send(24'h200, 16'h0003);
      chk(HIT_W'(ready), 2'b01, "R2 ready after ts change");
      look(1, 0);
      chk(HIT_W'(rd_count), 1, "R2 new count");
      chk(HIT_W'(rd_ts), 24'h200, "R2 new timestamp");
      chk_entry(1, 0, 24'h200, 16'h0003, "R2 new entry0");

      // R5: both buffers occupied -> discards
      send(24'h300, 16'h0004);
      exp_drop++;
      chk(HIT_W'(ready), 2'b11, "R5 both ready");
      send(24'h300, 16'h0005);
      exp_drop++;
      chk(HIT_W'(drop_count), exp_drop, "R5 drop count");
      look(1, 0);
      chk(HIT_W'(rd_count), 1, "R5 buffer1 count unchanged");
      chk_entry(1, 0, 24'h200, 16'h0003, "R5 buffer1 entry unchanged");
      look(0, 0);
      chk(HIT_W'(rd_count), 3, "R5 buffer0 count unchanged");

      // R7: release buffer 0; R6: second release ignored
      release_buf(0);
      chk(HIT_W'(ready), 2'b10, "R7 buffer0 released");
      release_buf(0);
      chk(HIT_W'(ready), 2'b10, "R6 repeat release ignored");
      look(1, 0);
      chk(HIT_W'(rd_count), 1, "R6 buffer1 count kept");
      chk(HIT_W'(rd_ts), 24'h200, "R6 buffer1 timestamp kept");

      // R3: DEPTH packets close the event on the last one
      send(24'h400, 16'h0006);
      send(24'h400, 16'h0007);
      send(24'h400, 16'h0008);
      chk(HIT_W'(ready), 2'b10, "R3 not closed before depth");
      send(24'h400, 16'h0009);
      chk(HIT_W'(ready), 2'b11, "R3 closed at depth");
      look(0, 0);
      chk(HIT_W'(rd_count), 4, "R3 full count");
      chk_entry(0, 3, 24'h400, 16'h0009, "R3 last entry");

      // R7: free both, same timestamp opens a new event in lowest buffer
      release_buf(1);
      release_buf(0);
      chk(HIT_W'(ready), 0, "R7 both released");
      idle_limit = 8'd3;
      send(24'h400, 16'h000A);
      look(0, 0);
      chk(HIT_W'(rd_count), 1, "R3 same ts after full opens new event");
      chk_entry(0, 0, 24'h400, 16'h000A, "R7 lowest buffer reused");

      // R4: timeout of 3 quiet edges
      @(negedge clk);
      @(negedge clk);
      chk(HIT_W'(ready), 0, "R4 open before timeout");
      @(negedge clk);
      chk(HIT_W'(ready), 2'b01, "R4 closed at timeout");

      // R4: timeout disabled
      idle_limit = 8'd0;
      send(24'h500, 16'h000B);
      repeat (20) @(negedge clk);
      chk(HIT_W'(ready), 2'b01, "R4 no timeout when disabled");
      send(24'h501, 16'h000C);
      exp_drop++;
      chk(HIT_W'(ready), 2'b11, "R5 close then discard");
      chk_counters("R8 counters before sweep");

      // R8/R9: sweep over all sources; every packet is discarded
      for (int s = 0; s < NSRC; s++) begin
         for (int k = 0; k <= s; k++) begin
            send(24'h600 + 24'(k), 16'((k << 8) | s));
            exp_drop++;
         end
      end
      chk_counters("R9 counters after sweep");

      // R10: clear wins over a same-cycle packet
      @(negedge clk);
      cnt_clear = 1'b1;
      in_valid  = 1'b1;
      in_ts     = 24'h700;
      in_addr   = 16'h0003;
      in_hits   = hit_of(24'h700, 16'h0003);
      @(negedge clk);
      cnt_clear = 1'b0;
      in_valid  = 1'b0;
      for (int s = 0; s < NSRC; s++) exp_cnt[s] = 0;
      exp_drop = 0;
      chk_counters("R10 after clear");
      send(24'h701, 16'h0007);
      exp_drop++;
      chk_counters("R10 count resumes after clear");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule